// File: doc/BRIEF.md
# Interrupting 32-bit GPIO Port

This block is one general-purpose I/O port of up to 32 pins behind a zero-wait APB-style register bus. Software sets a level for each pin in a data register and picks output or input for each pin in a direction register. The pin levels are read back through a two-flop synchronizer, so they are safe to use even when the pins are asynchronous.

Each pin also has its own interrupt cell. For each pin, software chooses:
- whether the interrupt is enabled,
- whether it is masked,
- level or edge sensing,
- active polarity,
- an override that fires on both edges.

Edge events are held in a latch until software writes a one to that pin's bit in the end-of-interrupt register. Level conditions are not held: they follow the synchronized pin. Every unmasked pending bit is ORed onto one level-sensitive interrupt line.

The bus follows APB timing without a ready signal. A transfer has a setup cycle, in which `psel` is high and `penable` is low, followed by an access cycle, in which both are high. A write takes effect at the clock edge that ends the access cycle. Read data is combinational during a read and is zero at all other times. The pins and the interrupt line are plain level signals with no handshake.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the following all read zero: `pin_out`, `pin_oe`, `irq`, data (0x00), direction (0x04), enable (0x30), mask (0x34), type (0x38), polarity (0x3C), both-edge (0x68), masked status (0x40), raw status (0x44).
- R2: The data register (0x00) and the direction register (0x04) read back what was written. From the cycle after the write, `pin_out` equals the data register and `pin_oe` equals the direction register. A direction bit of 1 means output.
- R3: The external input register (0x50) returns `pin_in` through two flops. A level present at one clock edge becomes readable after the following edge, and not before.
- R4: A pin whose bit in the enable register (0x30) is 0 reads 0 in raw status (0x44). Clearing the enable bit also discards that pin's held edge, so re-enabling the pin does not bring it back.
- R5: When a pin's type bit (0x38) is 0, the pin is level sensed. Its raw bit is then the synchronized level when its polarity bit (0x3C) is 1, and the inverted level when the polarity bit is 0. The raw bit is not held, and the end-of-interrupt register does not change it.
- R6: When a pin's type bit is 1, the pin is edge sensed. A rising synchronized transition sets the held raw bit when polarity is 1, and a falling transition sets it when polarity is 0. The bit stays set after the pin returns to its earlier level.
- R7: When a pin is edge sensed and its both-edge bit (0x68) is 1, either transition sets the held bit, whatever its polarity bit says.
- R8: Writing 1 to a bit of the end-of-interrupt register (0x4C) clears that pin's held edge. Writing 0 changes nothing, and the register reads as zero. If an edge arrives in the same cycle as the clear, the edge wins.
- R9: Masked status (0x40) equals raw status with every bit removed whose mask bit (0x34) is 1.
- R10: `irq` is high exactly while the masked status is nonzero.
- R11: The ID register (0x64) and the version register (0x6C) return fixed constants and ignore writes. Writes to raw status and masked status are ignored. Debounce (0x48) stores 32 bits. Level-sync (0x60) stores bit 0. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Levels driven onto the pins |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined level interrupt |

## Verification
A register write commits at the edge that ends its access cycle, so `pin_out`, `pin_oe` and `irq` are compared with a behavioural model at every falling edge after that.

A pin change applied at a falling edge has the following timing:
- It reaches the input register and any level-sensed status after the second rising edge.
- It sets an edge latch at the third rising edge.

The bench therefore waits four cycles after moving a pin before reading status. It also reads the input register one cycle after a change, where the old value is still expected. To hit the same-cycle race between a clear and an edge, the bench starts an end-of-interrupt write one cycle after a pin change, so the write commits on the same edge that sets the latch.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFS_DATA  = 'h00;
  localparam int unsigned OFS_DIR   = 'h04;
  localparam int unsigned OFS_IEN   = 'h30;
  localparam int unsigned OFS_IMASK = 'h34;
  localparam int unsigned OFS_ITYPE = 'h38;
  localparam int unsigned OFS_IPOL  = 'h3C;
  localparam int unsigned OFS_ISTAT = 'h40;
  localparam int unsigned OFS_IRAW  = 'h44;
  localparam int unsigned OFS_DEBNC = 'h48;
  localparam int unsigned OFS_EOI   = 'h4C;
  localparam int unsigned OFS_EXT   = 'h50;
  localparam int unsigned OFS_LSYNC = 'h60;
  localparam int unsigned OFS_IDENT = 'h64;
  localparam int unsigned OFS_BOTH  = 'h68;
  localparam int unsigned OFS_VER   = 'h6C;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else if (g == 0) begin
          stage_q[g] <= pin_i;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] edge_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] both_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             eoi_we_i,
  input  logic [WIDTH-1:0] eoi_bits_i,
  output logic [WIDTH-1:0] raw_o,
  output logic [WIDTH-1:0] stat_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] set_v;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_cell
      logic rise, fall, hit, armed, active_lvl;
      always_comb begin
        rise       = lvl_i[b] & ~prev_i[b];
        fall       = ~lvl_i[b] & prev_i[b];
        hit        = both_i[b] ? (rise | fall) : (pol_i[b] ? rise : fall);
        armed      = en_i[b] & edge_i[b];
        active_lvl = pol_i[b] ? lvl_i[b] : ~lvl_i[b];
        set_v[b]   = armed & hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          latch_q[b] <= 1'b0;
        else if (!armed)                     latch_q[b] <= 1'b0;
        else if (hit)                        latch_q[b] <= 1'b1;
        else if (eoi_we_i && eoi_bits_i[b])  latch_q[b] <= 1'b0;
      end

      assign raw_o[b] = en_i[b] & (edge_i[b] ? latch_q[b] : active_lvl);
    end
  endgenerate

  assign stat_o = raw_o & ~mask_i;
  assign irq_o  = |stat_o;

  AST_LATCH_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(set_v)) == '0)); // R6

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we_i |=> ((latch_q & $past(eoi_bits_i) & ~$past(set_v)) == '0)); // R8

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_i & ~mask_i) == '0) |-> !irq_o); // R10
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int          WIDTH     = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] ID_VALUE  = 32'h4750_4F31,
  parameter logic [31:0] VER_VALUE = 32'h0000_0102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WIDTH-1:0]  pwdata,
  output logic [WIDTH-1:0]  prdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  localparam int SYNC_STAGES = 2;

  bus_op_e op;
  logic    wr_en;
  logic [WIDTH-1:0] data_q, dir_q, ien_q, imask_q, itype_q, ipol_q, both_q, debnc_q;
  logic             lsync_q;
  logic [WIDTH-1:0] lvl, prev, raw, stat;
  logic             eoi_we;

  always_comb begin
    if (psel && penable) op = pwrite ? BUS_WRITE : BUS_READ;
    else                 op = BUS_IDLE;
  end
  assign wr_en  = (op == BUS_WRITE);
  assign eoi_we = wr_en && (paddr == ADDR_W'(OFS_EOI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      itype_q <= '0;
      ipol_q  <= '0;
      both_q  <= '0;
      debnc_q <= '0;
      lsync_q <= 1'b0;
    end else if (wr_en) begin
      case (paddr)
        ADDR_W'(OFS_DATA):  data_q  <= pwdata;
        ADDR_W'(OFS_DIR):   dir_q   <= pwdata;
        ADDR_W'(OFS_IEN):   ien_q   <= pwdata;
        ADDR_W'(OFS_IMASK): imask_q <= pwdata;
        ADDR_W'(OFS_ITYPE): itype_q <= pwdata;
        ADDR_W'(OFS_IPOL):  ipol_q  <= pwdata;
        ADDR_W'(OFS_BOTH):  both_q  <= pwdata;
        ADDR_W'(OFS_DEBNC): debnc_q <= pwdata;
        ADDR_W'(OFS_LSYNC): lsync_q <= pwdata[0];
        default: ;
      endcase
    end
  end

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_in),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  gpio_irq_bank #(.WIDTH(WIDTH)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl),
    .prev_i     (prev),
    .en_i       (ien_q),
    .edge_i     (itype_q),
    .pol_i      (ipol_q),
    .both_i     (both_q),
    .mask_i     (imask_q),
    .eoi_we_i   (eoi_we),
    .eoi_bits_i (pwdata),
    .raw_o      (raw),
    .stat_o     (stat),
    .irq_o      (irq)
  );

  always_comb begin
    prdata = '0;
    if (op == BUS_READ) begin
      case (paddr)
        ADDR_W'(OFS_DATA):  prdata = data_q;
        ADDR_W'(OFS_DIR):   prdata = dir_q;
        ADDR_W'(OFS_IEN):   prdata = ien_q;
        ADDR_W'(OFS_IMASK): prdata = imask_q;
        ADDR_W'(OFS_ITYPE): prdata = itype_q;
        ADDR_W'(OFS_IPOL):  prdata = ipol_q;
        ADDR_W'(OFS_ISTAT): prdata = stat;
        ADDR_W'(OFS_IRAW):  prdata = raw;
        ADDR_W'(OFS_DEBNC): prdata = debnc_q;
        ADDR_W'(OFS_EXT):   prdata = lvl;
        ADDR_W'(OFS_LSYNC): prdata = WIDTH'(lsync_q);
        ADDR_W'(OFS_IDENT): prdata = WIDTH'(ID_VALUE);
        ADDR_W'(OFS_BOTH):  prdata = both_q;
        ADDR_W'(OFS_VER):   prdata = WIDTH'(VER_VALUE);
        default:            prdata = '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && paddr == ADDR_W'(OFS_DIR)) |=> $stable(pin_oe)); // R2

  always_comb begin
    if (rst_n && op == BUS_READ && paddr == ADDR_W'(OFS_EOI))
      AST_EOI_READS_ZERO: assert (prdata == '0); // R8
  end
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [31:0] ID_EXP  = 32'h4750_4F31;
  localparam logic [31:0] VER_EXP = 32'h0000_0102;

  always #10 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_s1, m_s2, m_prev, m_data, m_dir, m_en, m_mask, m_type, m_pol, m_both, m_lat;

  function automatic logic [31:0] m_raw();
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = m_en[i] && (m_type[i] ? m_lat[i] : (m_pol[i] ? m_s2[i] : !m_s2[i]));
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_data = 0; m_dir = 0; m_en = 0;
      m_mask = 0; m_type = 0; m_pol = 0; m_both = 0; m_lat = 0;
    end else begin
      logic [31:0] s2o, pvo;
      logic wr;
      s2o = m_s2; pvo = m_prev;
      wr = psel && penable && pwrite;
      for (int i = 0; i < 32; i++) begin
        logic up, dn, ev;
        up = s2o[i] && !pvo[i];
        dn = !s2o[i] && pvo[i];
        ev = m_both[i] ? (up || dn) : (m_pol[i] ? up : dn);
        if (!(m_en[i] && m_type[i])) m_lat[i] = 1'b0;
        else if (ev) m_lat[i] = 1'b1;
        else if (wr && paddr == 8'h4C && pwdata[i]) m_lat[i] = 1'b0;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (wr) begin
        case (paddr)
          8'h00: m_data = pwdata;
          8'h04: m_dir  = pwdata;
          8'h30: m_en   = pwdata;
          8'h34: m_mask = pwdata;
          8'h38: m_type = pwdata;
          8'h3C: m_pol  = pwdata;
          8'h68: m_both = pwdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2 pin_out vs model", pin_out, m_data);
      chk("R2 pin_oe vs model", pin_oe, m_dir);
      chk("R10 irq vs model", {31'b0, irq}, {31'b0, |(m_raw() & ~m_mask)});
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pwdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1;
    chk(tag, prdata, exp);
    psel = 0; penable = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h00, 0, "R1 data"); rd(8'h04, 0, "R1 dir"); rd(8'h30, 0, "R1 en");
    rd(8'h34, 0, "R1 mask"); rd(8'h38, 0, "R1 type"); rd(8'h3C, 0, "R1 pol");
    rd(8'h68, 0, "R1 both"); rd(8'h40, 0, "R1 stat"); rd(8'h44, 0, "R1 raw");
    rd(8'h64, ID_EXP, "R11 id"); rd(8'h6C, VER_EXP, "R11 ver");

    // R2 data and direction
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_0000);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(8'h00, 32'hA5A5_0F0F, "R2 data rb");
    rd(8'h04, 32'hFFFF_0000, "R2 dir rb");

    // R3 input synchronizer delay
    tick(1);
    pin_in = 32'h1234_5678;
    rd(8'h50, 32'h0, "R3 ext not yet");
    tick(1);
    rd(8'h50, 32'h1234_5678, "R3 ext after sync");
    pin_in = 32'h0;
    tick(4);

    // R5 level sensing
    wr(8'h30, 32'h3);
    wr(8'h38, 32'h0);
    wr(8'h3C, 32'h2);
    tick(4);
    rd(8'h44, 32'h1, "R5 active-low level");
    chk("R10 irq level", {31'b0, irq}, 1);
    wr(8'h4C, 32'h1);
    rd(8'h44, 32'h1, "R5 eoi no effect on level");
    pin_in = 32'h3;
    tick(4);
    rd(8'h44, 32'h2, "R5 active-high level");
    rd(8'h40, 32'h2, "R9 stat unmasked");

    // R9 / R10 masking
    wr(8'h34, 32'h2);
    rd(8'h40, 32'h0, "R9 stat masked");
    rd(8'h44, 32'h2, "R9 raw unaffected by mask");
    tick(1);
    chk("R10 irq masked off", {31'b0, irq}, 0);
    wr(8'h34, 32'h0);

    // R6 / R7 edge sensing
    wr(8'h30, 32'hF0);
    wr(8'h38, 32'hF0);
    wr(8'h3C, 32'h90);
    wr(8'h68, 32'hC0);
    tick(4);
    rd(8'h44, 32'h0, "R6 no edge yet");
    pin_in = 32'hF3;
    tick(4);
    rd(8'h44, 32'hD0, "R6 R7 rising");
    pin_in = 32'h03;
    tick(4);
    rd(8'h44, 32'hF0, "R6 R7 falling held");
    wr(8'h4C, 32'h0);
    rd(8'h44, 32'hF0, "R8 eoi zero no effect");
    wr(8'h4C, 32'h30);
    rd(8'h44, 32'hC0, "R8 eoi clears");
    rd(8'h4C, 32'h0, "R8 eoi reads zero");

    // R4 disable discards held edge
    wr(8'h30, 32'h80);
    rd(8'h44, 32'h80, "R4 disabled bit zero");
    wr(8'h30, 32'hC0);
    rd(8'h44, 32'h80, "R4 reenable no stale");

    // R8 edge wins over same-cycle clear
    wr(8'h4C, 32'h80);
    rd(8'h44, 32'h0, "R8 cleared before race");
    tick(1);
    pin_in = 32'h83;
    tick(1);
    wr(8'h4C, 32'h80);
    rd(8'h44, 32'h80, "R8 edge wins race");

    // R11 storage, constants, read-only
    wr(8'h48, 32'hDEAD_BEEF);
    rd(8'h48, 32'hDEAD_BEEF, "R11 debounce");
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, 32'h1, "R11 level-sync");
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h44, 32'h80, "R11 raw read-only");
    wr(8'h64, 32'h0);
    rd(8'h64, ID_EXP, "R11 id read-only");
    wr(8'h6C, 32'h0);
    rd(8'h6C, VER_EXP, "R11 ver read-only");
    rd(8'h7C, 32'h0, "R11 unmapped");
    rd(8'h50, 32'h83, "R3 ext final");

    tick(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule